// File: doc/BRIEF.md
# Low-Voltage Reset Filter

This block turns two supply-comparator flags into a filtered reset request and a polled status register. One flag reports that the supply is at or below a falling trip level. The other reports that the supply is above a higher, rising trip level. Because the two thresholds differ, the block has hysteresis. The comparators, the references and the system reset tree sit outside the block. Both flags arrive as synchronous digital inputs.

Entry into reset is slow and exit is fast. A reset request is raised only after the supply has been low on nine consecutive clock cycles. It is dropped after a single cycle on which the supply is above the rising level. Short noise dips therefore never reach the reset tree. Two control bits have inverted sense. A power-down bit at 1 turns the whole filter off. A reset-disable bit at 1 stops reset requests, while the status flag keeps working so that software can poll the supply state.

Top module: `lv_reset_filter`

## Requirements
- R1: While `rst_n` is 0 at a clock edge, the filter clears its state. After that edge, `reset_req_o` is 0 and `rd_data_o` is 8'h00.
- R2: With `pwr_dn_i`=0 and `rst_dis_i`=0, `reset_req_o` rises at the clock edge that ends the ninth consecutive cycle with `vdd_low_i`=1. It stays 0 after only eight such cycles.
- R3: Any cycle with `vdd_low_i`=0 restarts the run count. Two bursts of eight low cycles separated by one non-low cycle raise no reset request.
- R4: Once `reset_req_o` is 1, it falls at the edge after one cycle with `vdd_ok_i`=1 and `vdd_low_i`=0. It holds its value on cycles where both flags are 0.
- R5: While `rst_dis_i`=1, `reset_req_o` is 0 at every edge, whatever the supply does. The status flag keeps tracking the supply.
- R6: The status flag is set at the edge after a cycle with `vdd_low_i`=1. It is cleared at the edge after a cycle with `vdd_ok_i`=1 and `vdd_low_i`=0. It holds its value when both flags are 0. `vdd_low_i` has priority when both flags are 1.
- R7: While `rd_strobe_i`=1, `rd_data_o` shows the status register: bit 7 is the status flag and bits 6 to 0 are 0. While `rd_strobe_i`=0, `rd_data_o` is 8'h00. The register has no write path.
- R8: A cycle with `pwr_dn_i`=1 clears the run count, the status flag and the reset request at the next edge. This holds even on the cycle that would have completed a nine-cycle run.
- R9: The run count saturates and never wraps. After any run of nine or more low cycles, clearing `rst_dis_i` while the supply stays low raises `reset_req_o` at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| vdd_low_i | input | 1 | Supply is at or below the falling trip level |
| vdd_ok_i | input | 1 | Supply is above the rising trip level |
| pwr_dn_i | input | 1 | 1 turns the filter off |
| rst_dis_i | input | 1 | 1 blocks reset requests |
| rd_strobe_i | input | 1 | Read strobe for the status register |
| reset_req_o | output | 1 | Filtered reset request |
| rd_data_o | output | 8 | Status register read data |

## Verification
Two functions can fall on the same edge: a power-down arriving on the cycle that completes the nine-cycle low run, and clearing the reset-disable bit while a saturated run is already in progress. The bench provokes the first with eight low cycles followed by a ninth low cycle that also has power-down asserted. It expects no request and a cleared flag. It provokes the second by holding disable through twenty low cycles and then releasing it, and expects the request on the next edge. A cycle-accurate model in the bench computes every expected value from the requirements. This includes a long pseudo-random run in which supply and control changes overlap freely.

// File: rtl/lvr_pkg.sv
// Package lvr_pkg
// Shared types for the low-voltage reset filter.
// Assumes the two comparator flags are already synchronous to clk.
package lvr_pkg;

    // Supply level class seen in one clock cycle
    typedef enum logic [1:0] {
        LVL_LOW = 2'd0,   // at or below the falling trip level
        LVL_MID = 2'd1,   // between the two trip levels
        LVL_OK  = 2'd2    // above the rising trip level
    } lvl_e;

    // Fold the two comparator flags into one class; the low flag wins
    function automatic lvl_e classify(input logic low, input logic ok);
        if (low)
            return LVL_LOW;
        else if (ok)
            return LVL_OK;
        else
            return LVL_MID;
    endfunction

endpackage

// File: rtl/lvr_run_counter.sv
// Module lvr_run_counter
// Counts consecutive low-supply cycles, saturating at TRIP_CYCLES.
// trip_o marks the cycle whose edge completes a run of TRIP_CYCLES.
// Assumes TRIP_CYCLES >= 2 and a synchronous active-low reset.
module lvr_run_counter
    import lvr_pkg::*;
#(
    parameter int TRIP_CYCLES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  lvl_e lvl_i,
    output logic trip_o
);

    localparam int CNT_W = $clog2(TRIP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TRIP_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRIP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             is_low;

    // Low cycle while the filter is on
    assign is_low = enable_i && (lvl_i == LVL_LOW);

    // Saturating run counter, cleared by any non-low or disabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!is_low)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    // This low cycle is the last one needed, or the run is already long enough
    assign trip_o = is_low && (cnt_q >= CNT_LAST);

    // R9: the count never exceeds its ceiling
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R9: a saturated count stays saturated through further low cycles
    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_low && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R3: a non-low cycle restarts the run
    p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i != LVL_LOW) |=> (cnt_q == '0));

    // R8: power-down clears the run
    p_cnt_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (cnt_q == '0));

endmodule

// File: rtl/lvr_hyst_flag.sv
// Module lvr_hyst_flag
// Low-voltage status flag with hysteresis: set by a low cycle, cleared
// by an above-rising-level cycle, held in between.
// Assumes a synchronous active-low reset.
module lvr_hyst_flag
    import lvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  lvl_e lvl_i,
    output logic flag_o
);

    logic flag_q;

    // Hysteretic set/clear of the status flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (!enable_i)
            flag_q <= 1'b0;
        else if (lvl_i == LVL_LOW)
            flag_q <= 1'b1;
        else if (lvl_i == LVL_OK)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R6: a low cycle sets the flag
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && lvl_i == LVL_LOW) |=> flag_q);

    // R6: a middle-band cycle leaves the flag unchanged
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && lvl_i == LVL_MID) |=> $stable(flag_q));

    // R8: power-down clears the flag
    p_flag_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !flag_q);

endmodule

// File: rtl/lvr_reset_ctl.sv
// Module lvr_reset_ctl
// Holds the reset request: raised on a completed low run, dropped
// after one above-rising-level cycle, suppressed by disable or power-down.
// Assumes a synchronous active-low reset.
module lvr_reset_ctl
    import lvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic rst_dis_i,
    input  lvl_e lvl_i,
    input  logic trip_i,
    output logic req_o
);

    logic req_q;

    // Request register with suppression having top priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (!enable_i || rst_dis_i)
            req_q <= 1'b0;
        else if (trip_i)
            req_q <= 1'b1;
        else if (lvl_i == LVL_OK)
            req_q <= 1'b0;
    end

    assign req_o = req_q;

    // R5: no request while disabled
    p_no_req_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_dis_i |=> !req_q);

    // R4: one good cycle releases the request
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && lvl_i == LVL_OK) |=> !req_q);

    // R4: a middle-band cycle holds an active request
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && enable_i && !rst_dis_i && lvl_i == LVL_MID) |=> req_q);

    // R8: power-down drops the request
    p_req_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !req_q);

endmodule

// File: rtl/lvr_status_port.sv
// Module lvr_status_port
// Read-only status register image: the flag sits at FLAG_BIT, every
// other bit reads 0. Data is driven only while the read strobe is high.
// Assumes FLAG_BIT < STAT_W. No write path exists.
module lvr_status_port #(
    parameter int STAT_W   = 8,
    parameter int FLAG_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              flag_i,
    output logic [STAT_W-1:0] rdata_o
);

    logic [STAT_W-1:0] image;

    // Build the register image bit by bit
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b == FLAG_BIT) begin : g_flag
            assign image[b] = flag_i;
        end else begin : g_zero
            assign image[b] = 1'b0;
        end
    end

    // Drive the image onto the read bus only during a read
    always_comb begin
        rdata_o = rd_i ? image : '0;
    end

    // R7: no read means an idle bus
    p_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (rdata_o == '0));

    // R7: only the flag bit may ever be set
    p_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rdata_o) <= 1);

endmodule

// File: rtl/lv_reset_filter.sv
// Module lv_reset_filter
// Top of the low-voltage reset filter: classifies the comparator flags,
// counts low runs, raises and releases the reset request and presents
// the polled status register.
// Assumes synchronous comparator flags and a synchronous active-low reset.
module lv_reset_filter
    import lvr_pkg::*;
#(
    parameter int TRIP_CYCLES = 9,
    parameter int STAT_W      = 8,
    parameter int FLAG_BIT    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vdd_low_i,
    input  logic              vdd_ok_i,
    input  logic              pwr_dn_i,
    input  logic              rst_dis_i,
    input  logic              rd_strobe_i,
    output logic              reset_req_o,
    output logic [STAT_W-1:0] rd_data_o
);

    lvl_e lvl;
    logic enable;
    logic trip;
    logic flag;

    // Level class and active-low module enable
    assign lvl    = classify(vdd_low_i, vdd_ok_i);
    assign enable = !pwr_dn_i;

    lvr_run_counter #(
        .TRIP_CYCLES (TRIP_CYCLES)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable),
        .lvl_i    (lvl),
        .trip_o   (trip)
    );

    lvr_hyst_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable),
        .lvl_i    (lvl),
        .flag_o   (flag)
    );

    lvr_reset_ctl u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable),
        .rst_dis_i (rst_dis_i),
        .lvl_i     (lvl),
        .trip_i    (trip),
        .req_o     (reset_req_o)
    );

    lvr_status_port #(
        .STAT_W   (STAT_W),
        .FLAG_BIT (FLAG_BIT)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (rd_strobe_i),
        .flag_i  (flag),
        .rdata_o (rd_data_o)
    );

    // R2: a new request always follows a low cycle
    p_rise_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req_o) |-> $past(vdd_low_i));

    // R2: a new request only follows a cycle with reset enabled
    p_rise_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req_o) |-> ($past(!rst_dis_i) && $past(!pwr_dn_i)));

endmodule

// File: tb/lv_reset_filter_tb.sv
`timescale 1ns/1ps
module lv_reset_filter_tb;

    localparam int TRIP = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vdd_low = 1'b0;
    logic       vdd_ok = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       rst_dis = 1'b0;
    logic       rd = 1'b0;
    logic       req;
    logic [7:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;

    // Requirement model state
    int   m_cnt  = 0;
    logic m_flag = 1'b0;
    logic m_req  = 1'b0;

    always #2.5 clk = ~clk;

    lv_reset_filter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .vdd_low_i   (vdd_low),
        .vdd_ok_i    (vdd_ok),
        .pwr_dn_i    (pwr_dn),
        .rst_dis_i   (rst_dis),
        .rd_strobe_i (rd),
        .reset_req_o (req),
        .rd_data_o   (rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp_v, $time);
        end
    endtask

    // Advance one cycle with the current inputs, then compare at the negedge
    task automatic tick(input string tag);
        int   n_cnt;
        logic n_flag, n_req;
        n_cnt = m_cnt; n_flag = m_flag; n_req = m_req;
        if (!rst_n || pwr_dn) begin
            n_cnt = 0; n_flag = 1'b0; n_req = 1'b0;
        end else begin
            n_cnt = vdd_low ? ((m_cnt < TRIP) ? m_cnt + 1 : TRIP) : 0;
            if (vdd_low)     n_flag = 1'b1;
            else if (vdd_ok) n_flag = 1'b0;
            if (rst_dis)                         n_req = 1'b0;
            else if (vdd_low && m_cnt >= TRIP-1) n_req = 1'b1;
            else if (!vdd_low && vdd_ok)         n_req = 1'b0;
        end
        @(negedge clk);
        m_cnt = n_cnt; m_flag = n_flag; m_req = n_req;
        check({tag, " req"}, {7'b0, req}, {7'b0, m_req});
        check({tag, " rdata"}, rdata, rd ? {m_flag, 7'b0} : 8'h00);
    endtask

    task automatic drive(input logic lo, input logic ok, input int n, input string tag);
        vdd_low = lo; vdd_ok = ok;
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; vdd_low = 1'b0; vdd_ok = 1'b0; pwr_dn = 1'b0; rst_dis = 1'b0; rd = 1'b1;
        tick("R1 reset");
        tick("R1 reset");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        do_reset();

        // R2 / R5: sweep run length and disable bit
        for (int dis = 0; dis < 2; dis++) begin
            for (int len = 0; len <= TRIP + 3; len++) begin
                do_reset();
                rst_dis = dis[0];
                rd = 1'b1;
                drive(1'b1, 1'b0, len, dis ? "R5 run" : "R2 run");
                drive(1'b0, 1'b0, 3, "R4 hold mid");
                drive(1'b0, 1'b1, 1, "R4 release");
                drive(1'b0, 1'b0, 2, "R6 flag clear");
            end
        end

        // R3: noise dip splits the run
        do_reset();
        drive(1'b1, 1'b0, TRIP-1, "R3 burst");
        drive(1'b0, 1'b0, 1, "R3 gap");
        drive(1'b1, 1'b0, TRIP-1, "R3 burst");
        drive(1'b0, 1'b1, 1, "R3 end");
        check("R3 no request", {7'b0, req}, 8'h00);

        // R6 / R7: hysteresis band with reads on and off
        do_reset();
        drive(1'b1, 1'b0, 1, "R6 set");
        rd = 1'b0;
        drive(1'b0, 1'b0, 4, "R7 idle bus");
        rd = 1'b1;
        drive(1'b0, 1'b0, 2, "R6 hold");
        drive(1'b1, 1'b1, 1, "R6 low priority");
        drive(1'b0, 1'b1, 1, "R6 clear");

        // R8: power-down on the completing cycle
        do_reset();
        drive(1'b1, 1'b0, TRIP-1, "R8 pre");
        pwr_dn = 1'b1;
        drive(1'b1, 1'b0, 1, "R8 pd on trip");
        check("R8 no request", {7'b0, req}, 8'h00);
        pwr_dn = 1'b0;
        drive(1'b1, 1'b0, TRIP-1, "R8 restart");
        check("R8 count restarted", {7'b0, req}, 8'h00);
        drive(1'b1, 1'b0, 2, "R8 trip again");
        pwr_dn = 1'b1;
        drive(1'b1, 1'b0, 1, "R8 clear active");

        // R9: saturation then releasing the disable
        do_reset();
        pwr_dn = 1'b0;
        rst_dis = 1'b1;
        drive(1'b1, 1'b0, 20, "R9 long run");
        rst_dis = 1'b0;
        drive(1'b1, 1'b0, 1, "R9 enable");
        check("R9 immediate request", {7'b0, req}, 8'h01);
        drive(1'b1, 1'b0, 40, "R9 hold");

        // Mixed pseudo-random stimulus against the model
        do_reset();
        lfsr = 8'hA5;
        for (int c = 0; c < 4000; c++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            vdd_low = (lfsr[2:0] != 3'b000);
            vdd_ok  = !vdd_low && lfsr[3];
            pwr_dn  = (lfsr[7:3] == 5'b00000);
            rd      = lfsr[5];
            rst_dis = (c % 512) >= 384;
            tick("R4 mixed");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule